// File: doc/BRIEF.md
# Cascadable Serial-In Latched Display Driver Core

This block is the logic core of a multi-channel display driver. A serial bit stream enters a shift chain one bit per rising clock edge. A level-sensitive load control copies the chain into a bank of hold registers. A blanking control forces every parallel output low at once. The last chain stage appears on a serial output. Several drivers can therefore be chained: each one's serial output feeds the next one's serial input.

In normal use a controller shifts in a full frame while the hold registers keep showing the previous frame. It then raises the load control for one cycle to update the display. The blanking control is used on its own to switch the display off and on. The whole block runs in one clock domain. The load control is sampled on the clock, so the hold registers load on every edge for as long as it stays high.

Top module: `vfd_serial_driver`

## Requirements
- R1: The block has CHANNELS shift stages, CHANNELS hold registers and CHANNELS parallel outputs (default 32), one per stage.
- R2: On each rising clock edge outside reset, `ser_in` enters stage 0 (`drive_out[0]`) and each stage k takes the old value of stage k-1. After CHANNELS edges, the first bit shifted in sits in stage CHANNELS-1 (`drive_out[CHANNELS-1]`).
- R3: A rising edge with `latch_en` high loads the hold registers with the shift-chain contents as they stand after that edge. While `latch_en` stays high, the hold registers follow the chain on every edge.
- R4: A rising edge with `latch_en` low leaves the hold registers unchanged, whatever shifting takes place.
- R5: While `blank` is high, every bit of `drive_out` is 0. While `blank` is low, `drive_out` equals the hold registers. `blank` acts combinationally.
- R6: `ser_out` equals the last shift stage. It changes only on rising clock edges, so after an edge it shows the value that stage CHANNELS-2 had before that edge.
- R7: A rising edge with `rst` high clears the shift chain and the hold registers to all zeros.
- R8: When two blocks are chained, shifting a 2*CHANNELS-bit word MSB first and then loading leaves the upper half on the far device and the lower half on the near device. Each half reads back bit-for-bit on `drive_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; shift and load take place on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 0 |
| latch_en | input | 1 | High: hold registers load from the chain on each edge |
| blank | input | 1 | High: all parallel outputs forced low |
| drive_out | output | CHANNELS | Parallel outputs; bit k is channel k+1 |
| ser_out | output | 1 | Last shift stage, for chaining |

## Verification
The bench builds two instances with the default CHANNELS of 32 and wires the first one's serial output into the second one's serial input. This exposes a 64-stage chain. With it, the cascade ordering, the full-depth bit placement on both devices, and the serial hand-off between them can all be observed at the ports. A reference model of both devices also follows long random runs. In those runs the load and blank controls toggle independently, so hold-during-shift, continuous loading and blanking of stale or fresh data all occur in many combinations.

// File: rtl/dd_pkg.sv
package dd_pkg;
    localparam int DEFAULT_CHANNELS = 32;

    typedef struct packed {
        logic rst;
        logic ser_in;
        logic latch_en;
        logic blank;
    } drv_ctrl_t;
endpackage

// File: rtl/dd_shift_chain.sv
module dd_shift_chain #(
    parameter int CHANNELS = dd_pkg::DEFAULT_CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_in,
    output logic [CHANNELS-1:0] bits_now,
    output logic [CHANNELS-1:0] bits_next,
    output logic                last_stage
);
    localparam int TOP = CHANNELS - 1;

    typedef struct packed {
        logic [CHANNELS-1:0] bits;
    } chain_t;

    chain_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.bits = '0;
        end else begin
            state_d.bits = {state_q.bits[TOP-1:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign bits_now   = state_q.bits;
    assign bits_next  = state_d.bits;
    assign last_stage = state_q.bits[TOP];
endmodule

// File: rtl/dd_hold_latch.sv
module dd_hold_latch #(
    parameter int CHANNELS = dd_pkg::DEFAULT_CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [CHANNELS-1:0] src,
    output logic [CHANNELS-1:0] held
);
    typedef struct packed {
        logic [CHANNELS-1:0] bits;
    } hold_t;

    hold_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.bits = '0;
        end else if (load) begin
            state_d.bits = src;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign held = state_q.bits;
endmodule

// File: rtl/dd_out_gate.sv
module dd_out_gate #(
    parameter int CHANNELS = dd_pkg::DEFAULT_CHANNELS
) (
    input  logic                blank,
    input  logic [CHANNELS-1:0] held,
    output logic [CHANNELS-1:0] drive
);
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        assign drive[ch] = held[ch] & ~blank;
    end
endmodule

// File: rtl/vfd_serial_driver.sv
module vfd_serial_driver #(
    parameter int CHANNELS = dd_pkg::DEFAULT_CHANNELS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_in,
    input  logic                latch_en,
    input  logic                blank,
    output logic [CHANNELS-1:0] drive_out,
    output logic                ser_out
);
    dd_pkg::drv_ctrl_t ctrl;
    logic [CHANNELS-1:0] shift_bits;
    logic [CHANNELS-1:0] shift_next;
    logic [CHANNELS-1:0] held_bits;

    always_comb begin
        ctrl.rst      = rst;
        ctrl.ser_in   = ser_in;
        ctrl.latch_en = latch_en;
        ctrl.blank    = blank;
    end

    dd_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
        .clk        (clk),
        .rst        (ctrl.rst),
        .ser_in     (ctrl.ser_in),
        .bits_now   (shift_bits),
        .bits_next  (shift_next),
        .last_stage (ser_out)
    );

    dd_hold_latch #(.CHANNELS(CHANNELS)) u_hold (
        .clk  (clk),
        .rst  (ctrl.rst),
        .load (ctrl.latch_en),
        .src  (shift_next),
        .held (held_bits)
    );

    dd_out_gate #(.CHANNELS(CHANNELS)) u_gate (
        .blank (ctrl.blank),
        .held  (held_bits),
        .drive (drive_out)
    );
endmodule

// File: rtl/vfd_serial_driver_chk.sv
module vfd_serial_driver_chk #(
    parameter int CHANNELS = dd_pkg::DEFAULT_CHANNELS
) (
    input logic                clk,
    input logic                rst,
    input logic                ser_in,
    input logic                latch_en,
    input logic                blank,
    input logic [CHANNELS-1:0] drive_out,
    input logic                ser_out,
    input logic [CHANNELS-1:0] shift_bits,
    input logic [CHANNELS-1:0] held_bits
);
    a_r2_stage0_takes_input: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> shift_bits[0] == $past(ser_in));

    a_r2_stage_moves_up: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> shift_bits[CHANNELS-1:1] == $past(shift_bits[CHANNELS-2:0]));

    a_r3_load_follows_chain: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> held_bits == shift_bits);

    a_r4_hold_when_closed: assert property (@(posedge clk) disable iff (rst)
        !latch_en |=> $stable(held_bits));

    a_r5_blank_forces_low: assert property (@(posedge clk) disable iff (rst)
        blank |-> drive_out == '0);

    a_r5_unblanked_shows_hold: assert property (@(posedge clk) disable iff (rst)
        !blank |-> drive_out == held_bits);

    a_r6_serial_out_shift: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ser_out == $past(shift_bits[CHANNELS-2]));

    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (shift_bits == '0) && (held_bits == '0) && !ser_out);
endmodule

bind vfd_serial_driver vfd_serial_driver_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .latch_en   (latch_en),
    .blank      (blank),
    .drive_out  (drive_out),
    .ser_out    (ser_out),
    .shift_bits (shift_bits),
    .held_bits  (held_bits)
);

// File: tb/vfd_serial_driver_tb_top.sv
`timescale 1ns/1ps
module vfd_serial_driver_tb_top;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic le = 1'b0;
    logic blk = 1'b0;
    logic [N-1:0] out_a, out_b;
    logic so_a, so_b;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_sr_a = '0, m_sr_b = '0, m_lat_a = '0, m_lat_b = '0;

    always #2 clk = ~clk;

    vfd_serial_driver #(.CHANNELS(N)) dut_i (
        .clk(clk), .rst(rst), .ser_in(din), .latch_en(le), .blank(blk),
        .drive_out(out_a), .ser_out(so_a)
    );

    vfd_serial_driver #(.CHANNELS(N)) dut_b (
        .clk(clk), .rst(rst), .ser_in(so_a), .latch_en(le), .blank(blk),
        .drive_out(out_b), .ser_out(so_b)
    );

    function automatic logic [N-1:0] gate(input logic [N-1:0] h, input logic b);
        return b ? '0 : h;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, update model at posedge, sample 1 ns after the edge.
    task automatic step(input logic r, input logic d, input logic l, input logic b);
        logic [N-1:0] na, nb;
        @(negedge clk);
        rst = r; din = d; le = l; blk = b;
        @(posedge clk);
        if (r) begin
            na = '0; nb = '0;
            m_lat_a = '0; m_lat_b = '0;
        end else begin
            na = {m_sr_a[N-2:0], d};
            nb = {m_sr_b[N-2:0], m_sr_a[N-1]};
            if (l) begin
                m_lat_a = na; m_lat_b = nb;
            end
        end
        m_sr_a = na; m_sr_b = nb;
        #1;
    endtask

    task automatic check_model(input string req);
        chk({req, " near outputs"}, 64'(out_a), 64'(gate(m_lat_a, blk)));
        chk({req, " far outputs"}, 64'(out_b), 64'(gate(m_lat_b, blk)));
        chk({req, " serial out"}, 64'(so_a), 64'(m_sr_a[N-1]));
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] pat;
        logic [63:0] w64;
        void'($urandom(32'd2718));

        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R7 reset state
        chk("R7 reset outputs", 64'(out_a), 64'd0);
        chk("R7 reset serial out", 64'(so_a), 64'd0);

        // R2 / R1: full-depth placement, first bit lands on top channel
        pat = 32'hA5C3_0F17;
        for (int i = N - 1; i >= 0; i--) step(0, pat[i], 0, 0);
        chk("R4 hold during shift", 64'(out_a), 64'd0);
        step(0, 1'b0, 1, 0);
        chk("R2 R3 placement after load", 64'(out_a), 64'({pat[N-2:0], 1'b0}));
        chk("R6 serial out shows top stage", 64'(so_a), 64'(pat[N-2]));

        // R4: shift new data with load low; outputs keep previous frame
        for (int i = 0; i < 20; i++) step(0, 1'b1, 0, 0);
        chk("R4 hold after shifting", 64'(out_a), 64'({pat[N-2:0], 1'b0}));

        // R5: blanking hides and restores the held frame
        step(0, 1'b0, 0, 1);
        chk("R5 blank forces low", 64'(out_a), 64'd0);
        @(negedge clk); blk = 1'b0; #0.5;
        chk("R5 unblank combinational", 64'(out_a), 64'({pat[N-2:0], 1'b0}));

        // R8: cascade of two devices, 64-bit word MSB first
        step(1, 0, 0, 0);
        w64 = 64'h1234_5678_9ABC_DEF0;
        for (int i = 63; i >= 1; i--) step(0, w64[i], 0, 0);
        step(0, w64[0], 1, 0);
        chk("R8 near device lower half", 64'(out_a), 64'(w64[31:0]));
        chk("R8 far device upper half", 64'(out_b), 64'(w64[63:32]));

        // R3: continuous load makes outputs follow the chain
        step(0, 1'b1, 1, 0);
        chk("R3 transparent follow", 64'(out_a), 64'({w64[30:0], 1'b1}));

        // Random mix against the reference model (R2-R6, R8)
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 97) == 0, 1'($urandom), ($urandom % 6) == 0,
                 ($urandom % 4) == 0);
            check_model("R2 R3 R4 R5 R6 R8 random");
        end

        // R7: reset mid-operation clears everything
        step(0, 1'b1, 1, 0);
        step(1, 1'b1, 1, 0);
        chk("R7 mid reset near", 64'(out_a), 64'd0);
        chk("R7 mid reset far", 64'(out_b), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule